// File: doc/BRIEF.md
# Address Window Switch Sequencer

This block moves a host-side address window so that it points at one of several on-chip cores, and it does not accept the new mapping until it has confirmed it. A caller presents a core index on a valid/ready request channel. The sequencer computes the window base for that core and writes it to the window register over a simple request/acknowledge register port. It then reads the register back and turns the value read into a core index. If that index differs from the request, it waits a fixed time and repeats the write and readback. It stops with an error once its attempt budget is spent, or at once if the register port reports a bus fault.

The sequencer keeps track of which core the window currently maps. A request for that core completes in one cycle and causes no register traffic. A successful switch records the new core. An error drops the record, because the window contents are then unknown.

Back-pressure rules: `req_ready` is high only while the sequencer is idle. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The caller holds `req_core` steady while `req_valid` is high and `req_ready` is low. The response is a single-cycle pulse on `rsp_valid` that cannot be stalled. The register port keeps `reg_req`, `reg_we` and `reg_wdata` steady until it sees `reg_ack`.

Top module: `win_switch_seq`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid`, `reg_req` and `mapped_valid` are 0.
- R2: The window write carries `WIN_BASE + core * 2**REGION_LOG2` (defaults: base 0x1800_0000, 4 KiB regions, so core 3 gives 0x1800_3000). Request fields stay steady until `reg_ack`.
- R3: Each accepted write is followed by a read of the register (`reg_we`=0). The value read is converted as `(value - WIN_BASE) >> REGION_LOG2`, so the offset bits below the region size play no part. When the result equals the request, `rsp_valid`=1 with `rsp_err`=0 in the cycle after the read acknowledge.
- R4: On a mismatching readback the sequencer stays off the register port. It raises the next write request DELAY_CYC+1 cycles after the cycle of the mismatching read acknowledge, where DELAY_CYC = CLK_MHZ*DELAY_US (default 2500).
- R5: After MAX_RETRY+2 mismatching readbacks in a row (default 5), the sequencer ends with `rsp_err`=1 and has issued exactly MAX_RETRY+2 window writes.
- R6: A `reg_fail` on a write or on a read ends the sequence in the next cycle with `rsp_err`=1. No further register access follows.
- R7: A successful switch sets `mapped_valid`=1 and `mapped_core` to the requested core.
- R8: A request for the core already mapped (with `mapped_valid`=1) gives `rsp_valid`=1, `rsp_err`=0 in the next cycle and no register access.
- R9: An error response clears `mapped_valid`.
- R10: `req_ready` is 0 from the cycle after a request that needs a switch is accepted until that switch completes.
- R11: `rsp_core` equals the core index of the request being answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Switch request valid |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_core | input | IDX_W | Target core index |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion is an error |
| rsp_core | output | IDX_W | Core index of the completed request |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_wdata | output | ADDR_W | Window value to write |
| reg_ack | input | 1 | Register access complete |
| reg_fail | input | 1 | Access faulted (valid with reg_ack) |
| reg_rdata | input | ADDR_W | Read value (valid with reg_ack) |
| mapped_valid | output | 1 | A core is known to be mapped |
| mapped_core | output | IDX_W | Currently mapped core |

## Verification
The embedded properties assume the register port raises `reg_ack` only while `reg_req` is high, and for at most one cycle per access. They also assume `req_core` does not change while a request waits on `req_ready`. The bench's register model acknowledges each access once, one cycle after it appears, and then drops the acknowledge. The request driver holds the index until the request is accepted. Readback corruption, offset bits and faults are injected only through the values the model returns, so the request/acknowledge pairing stays legal in every scenario.

// File: rtl/win_switch_pkg.sv
package win_switch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2,
    ST_WAIT = 2'd3
  } sw_state_e;
endpackage

// File: rtl/win_addr_xlat.sv
module win_addr_xlat #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned REGION_LOG2 = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h1800_0000
) (
  input  logic [IDX_W-1:0]  core,
  input  logic [ADDR_W-1:0] rb_value,
  output logic [ADDR_W-1:0] win_addr,
  output logic              rb_match
);
  localparam int unsigned Q_W = ADDR_W - REGION_LOG2;

  logic [ADDR_W-1:0] rel;
  logic [Q_W-1:0]    quot;

  assign win_addr = WIN_BASE + (ADDR_W'(core) << REGION_LOG2);
  assign rel      = rb_value - WIN_BASE;
  assign quot     = rel[ADDR_W-1:REGION_LOG2];

  generate
    if (Q_W > IDX_W) begin : g_wide
      assign rb_match = (quot[Q_W-1:IDX_W] == '0) && (quot[IDX_W-1:0] == core);
    end else begin : g_exact
      assign rb_match = (quot == core[Q_W-1:0]);
    end
  endgenerate
endmodule

// File: rtl/win_delay_timer.sv
module win_delay_timer #(
  parameter int unsigned DELAY_CYC = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int unsigned TW = $clog2(DELAY_CYC + 1);

  logic [TW-1:0] cnt;
  logic          busy;

  assign expired = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= TW'(DELAY_CYC - 1);
      busy <= 1'b1;
    end else if (expired) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_TMR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= TW'(DELAY_CYC - 1)));  // R4
  AST_TMR_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !expired && !start) |=> (busy && cnt == $past(cnt) - 1'b1));  // R4
endmodule

// File: rtl/win_attempt_ctr.sv
module win_attempt_ctr #(
  parameter int unsigned MAX_RETRY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic over
);
  localparam int unsigned AW = $clog2(MAX_RETRY + 2) + 1;

  logic [AW-1:0] cnt;

  assign over = (cnt > AW'(MAX_RETRY));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc && !over) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_ATT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= AW'(MAX_RETRY + 1));  // R5
endmodule

// File: rtl/win_switch_seq.sv
module win_switch_seq
  import win_switch_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned REGION_LOG2 = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h1800_0000,
  parameter int unsigned MAX_RETRY   = 3,
  parameter int unsigned CLK_MHZ     = 250,
  parameter int unsigned DELAY_US    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_core,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [IDX_W-1:0]  rsp_core,
  output logic              reg_req,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_wdata,
  input  logic              reg_ack,
  input  logic              reg_fail,
  input  logic [ADDR_W-1:0] reg_rdata,
  output logic              mapped_valid,
  output logic [IDX_W-1:0]  mapped_core
);
  localparam int unsigned DELAY_CYC = (CLK_MHZ * DELAY_US < 1) ? 1 : CLK_MHZ * DELAY_US;

  sw_state_e        state;
  logic [IDX_W-1:0] core_q;
  logic             done_q, err_q;
  logic             map_v;
  logic [IDX_W-1:0] map_c;

  logic [ADDR_W-1:0] win_addr;
  logic              rb_match;
  logic              att_over;
  logic              tmr_expired;
  logic              accept, hit;
  logic              rd_ok, rd_miss;

  win_addr_xlat #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .REGION_LOG2(REGION_LOG2), .WIN_BASE(WIN_BASE)
  ) u_xlat (
    .core(core_q), .rb_value(reg_rdata), .win_addr(win_addr), .rb_match(rb_match)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hit       = map_v && (map_c == req_core);
  assign rd_ok     = (state == ST_RD) && reg_ack && !reg_fail;
  assign rd_miss   = rd_ok && !rb_match;

  win_attempt_ctr #(.MAX_RETRY(MAX_RETRY)) u_att (
    .clk(clk), .rst_n(rst_n),
    .clr(accept && !hit), .inc(rd_miss), .over(att_over)
  );

  win_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .start(rd_miss && !att_over), .expired(tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      core_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      map_v  <= 1'b0;
      map_c  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            core_q <= req_core;
            if (hit) done_q <= 1'b1;
            else      state  <= ST_WR;
          end
        end
        ST_WR: begin
          if (reg_ack) begin
            if (reg_fail) begin
              err_q <= 1'b1;
              map_v <= 1'b0;
              state <= ST_IDLE;
            end else begin
              state <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (reg_ack) begin
            if (reg_fail || (!rb_match && att_over)) begin
              err_q <= 1'b1;
              map_v <= 1'b0;
              state <= ST_IDLE;
            end else if (rb_match) begin
              done_q <= 1'b1;
              map_v  <= 1'b1;
              map_c  <= core_q;
              state  <= ST_IDLE;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (tmr_expired) state <= ST_WR;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reg_req      = (state == ST_WR) || (state == ST_RD);
  assign reg_we       = (state == ST_WR);
  assign reg_wdata    = win_addr;
  assign rsp_valid    = done_q || err_q;
  assign rsp_err      = err_q;
  assign rsp_core     = core_q;
  assign mapped_valid = map_v;
  assign mapped_core  = map_c;

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_we) && $stable(reg_wdata)));  // R2
  AST_WR_THEN_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_ack && !reg_fail) |=> (reg_req && !reg_we));  // R3
  AST_FAIL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_ack && reg_fail) |=> (!reg_req && rsp_valid && rsp_err));  // R6
  AST_OK_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> (mapped_valid && mapped_core == rsp_core));  // R7
  AST_HIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && mapped_valid && req_core == mapped_core)
      |=> (!reg_req && rsp_valid && !rsp_err));  // R8
  AST_ERR_UNMAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> !mapped_valid);  // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> !req_ready);  // R10
endmodule

// File: tb/sim_win_switch_seq.sv
`timescale 1ns/1ps
module sim_win_switch_seq;
  localparam int unsigned AW = 32;
  localparam int unsigned IW = 4;
  localparam int unsigned MAXR = 3;
  localparam int unsigned DLY = 2500;
  localparam logic [31:0] BASE = 32'h1800_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [IW-1:0] req_core = '0;
  logic rsp_valid, rsp_err;
  logic [IW-1:0] rsp_core;
  logic reg_req, reg_we;
  logic [AW-1:0] reg_wdata;
  logic reg_ack = 1'b0;
  logic reg_fail = 1'b0;
  logic [AW-1:0] reg_rdata = '0;
  logic mapped_valid;
  logic [IW-1:0] mapped_core;

  always #2 clk = ~clk;

  win_switch_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_core(req_core),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_core(rsp_core),
    .reg_req(reg_req), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_fail(reg_fail), .reg_rdata(reg_rdata),
    .mapped_valid(mapped_valid), .mapped_core(mapped_core)
  );

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // register model
  logic [31:0] winreg = 32'h0;
  int n_wr = 0, n_rd = 0;
  int bad_reads = 0;
  bit fail_wr = 0, fail_rd = 0;
  logic [31:0] rd_off = 0;
  int miss_cyc = -1;
  int last_gap = -1;

  always @(negedge clk) begin
    cyc++;
    if (reg_ack) begin
      reg_ack = 1'b0;
      reg_fail = 1'b0;
    end else if (reg_req) begin
      reg_ack = 1'b1;
      if (reg_we) begin
        n_wr++;
        if (miss_cyc >= 0) begin
          last_gap = cyc - miss_cyc;
          miss_cyc = -1;
        end
        if (fail_wr) begin
          reg_fail = 1'b1;
          fail_wr = 0;
        end else begin
          winreg = reg_wdata;
        end
      end else begin
        n_rd++;
        if (fail_rd) begin
          reg_fail = 1'b1;
          fail_rd = 0;
        end else if (bad_reads > 0) begin
          reg_rdata = winreg + 32'h1000;
          bad_reads--;
          miss_cyc = cyc;
        end else begin
          reg_rdata = winreg | rd_off;
        end
      end
    end
  end

  // scoreboard
  typedef struct packed { logic [IW-1:0] core; logic err; } exp_t;
  exp_t exp_q[$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected response", {31'b0, rsp_err}, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_err == e.err, "R3/R5/R6 response error flag", {31'b0, rsp_err}, {31'b0, e.err});
        check(rsp_core == e.core, "R11 response core", {28'b0, rsp_core}, {28'b0, e.core});
      end
    end
  end

  task automatic issue(input logic [IW-1:0] core, input logic err, input bit is_hit);
    exp_t e;
    e.core = core;
    e.err = err;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1;
    req_core = core;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!is_hit)
      check(req_ready == 1'b0, "R10 ready low while switching", {31'b0, req_ready}, 32'h0);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready in reset", {31'b0, req_ready}, 32'h1);
    check(rsp_valid == 1'b0, "R1 no response in reset", {31'b0, rsp_valid}, 32'h0);
    check(reg_req == 1'b0, "R1 no register access in reset", {31'b0, reg_req}, 32'h0);
    check(mapped_valid == 1'b0, "R1 nothing mapped in reset", {31'b0, mapped_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mapped_valid == 1'b0 && req_ready == 1'b1, "R1 state after reset", {31'b0, mapped_valid}, 32'h0);

    // plain switch to core 3
    issue(4'd3, 1'b0, 1'b0);
    check(winreg == BASE + 32'h3000, "R2 window value core 3", winreg, BASE + 32'h3000);
    check(n_wr == 1 && n_rd == 1, "R3 one write one read", n_wr * 16 + n_rd, 32'h11);
    check(mapped_valid && mapped_core == 4'd3, "R7 mapped core 3", {27'b0, mapped_valid, mapped_core}, 32'h13);

    // same core again: no traffic
    begin
      int w0, r0;
      w0 = n_wr; r0 = n_rd;
      issue(4'd3, 1'b0, 1'b1);
      check(n_wr == w0 && n_rd == r0, "R8 hit makes no register access", n_wr + n_rd, w0 + r0);
    end

    // readback with offset bits inside the region
    rd_off = 32'h0000_0ABC;
    issue(4'd5, 1'b0, 1'b0);
    rd_off = 0;
    check(mapped_core == 4'd5 && mapped_valid, "R3 offset bits ignored", {28'b0, mapped_core}, 32'h5);

    // two bad readbacks then success
    begin
      int w0;
      w0 = n_wr;
      bad_reads = 2;
      issue(4'd7, 1'b0, 1'b0);
      check(n_wr - w0 == 3, "R4 retries after mismatch", n_wr - w0, 32'd3);
      check(last_gap == DLY + 1, "R4 delay before rewrite", last_gap, DLY + 1);
      check(mapped_core == 4'd7, "R7 mapped core 7", {28'b0, mapped_core}, 32'h7);
    end

    // readback never matches
    begin
      int w0;
      w0 = n_wr;
      bad_reads = 99;
      issue(4'd9, 1'b1, 1'b0);
      bad_reads = 0;
      check(n_wr - w0 == MAXR + 2, "R5 attempts before error", n_wr - w0, MAXR + 2);
      check(mapped_valid == 1'b0, "R9 error clears mapping", {31'b0, mapped_valid}, 32'h0);
    end

    // write fault
    begin
      int r0, w0;
      r0 = n_rd; w0 = n_wr;
      fail_wr = 1;
      issue(4'd2, 1'b1, 1'b0);
      repeat (3) @(negedge clk);
      check(n_rd == r0 && n_wr == w0 + 1, "R6 write fault stops sequence", n_rd - r0, 32'h0);
    end

    // success then read fault
    issue(4'd2, 1'b0, 1'b0);
    check(mapped_valid && mapped_core == 4'd2, "R7 mapped core 2", {28'b0, mapped_core}, 32'h2);
    begin
      int r0, w0;
      r0 = n_rd; w0 = n_wr;
      fail_rd = 1;
      issue(4'd4, 1'b1, 1'b0);
      repeat (3) @(negedge clk);
      check(n_rd == r0 + 1 && n_wr == w0 + 1, "R6 read fault stops sequence", n_wr - w0, 32'h1);
      check(mapped_valid == 1'b0, "R9 read fault clears mapping", {31'b0, mapped_valid}, 32'h0);
    end

    // highest index
    issue(4'd15, 1'b0, 1'b0);
    check(winreg == BASE + 32'hF000, "R2 window value core 15", winreg, BASE + 32'hF000);
    check(mapped_core == 4'd15, "R11 mapped core 15", {28'b0, mapped_core}, 32'hF);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule